// File: doc/BRIEF.md
# PCI Configuration Address Translator

This block sits between a processor bus and the configuration mechanism of a PCI host bridge. Software writes a 32-bit word to a 4 KiB address window. In that word the target device is chosen by a one-hot select bit somewhere in bits 31..11. The block does not take a device number directly. It scans for the lowest set select bit, turns its index into a device number, and latches an enabled bus/device/function/register configuration address. Downstream logic uses that address when it runs the configuration data cycles. A read of the window rebuilds the one-hot form from the latched address.

A second 4 KiB window is decoded 0x400000 above the first. The block only flags hits on it; it performs no data cycles there. A big-endian input swaps the byte order of words going in and coming out. The interrupt pins of the devices are folded onto four shared lines, which sit at an offset in a wider interrupt vector. A flag reports when the latched address targets the host bridge itself. Design note: the block has no state machine. It has one latched register, scan logic and readback logic, and every access completes in one cycle.

Top module: `pcx_cfg_xlate`

## Requirements
- R1: After reset `cfg_addr` is 0 and a little-endian read of the address window returns 0x00000001.
- R2: A write to the address window (cpu_sel=1, cpu_we=1) latches the following on the clock edge:
  - bit 31 is set;
  - bits 15:11 hold the index of the lowest set bit among bits 31..11 of the word;
  - bits 10:2 are copied from the word;
  - bits 30:16 and 1:0 are zero.
- R3: If none of bits 31..11 of the written word is set, the scan index is 32. The latched address then has bit 16 set (bus field = 1) and bits 15:11 are zero.
- R4: A read of the address window (cpu_sel=1, cpu_we=0) combinationally returns the OR of three parts of the latched address L:
  - a single one at bit position L[15:11];
  - L[10:8] in bits 10:8;
  - L[7:2] in bits 7:2.
- R5: With big_endian=1, the written word is byte-reversed before the scan and field copy, and the read result is byte-reversed after it is built.
- R6: `addr_win_hit` is high when cpu_addr lies in the 4 KiB window at ADDR_BASE. `data_win_hit` is high when cpu_addr lies in the 4 KiB window at ADDR_BASE+0x400000. A write whose address is outside the address window leaves `cfg_addr` unchanged.
- R7: A read (cpu_we=0) or an access with cpu_sel=0 leaves `cfg_addr` unchanged.
- R8: Interrupt pin p of device s (dev_irq bit s*4+p) drives irq_line bit 8 + ((p+s) mod 4). All other irq_line bits stay 0.
- R9: `cfg_is_host` is high exactly when the enable bit is set, the bus field is zero and the device field equals 11.
- R10: `cpu_rdata` is 0 unless a read of the address window is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| big_endian | input | 1 | Byte-reverse written and read words |
| cpu_sel | input | 1 | Bus access strobe |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Bus byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data (combinational) |
| addr_win_hit | output | 1 | Address falls in the address-register window |
| data_win_hit | output | 1 | Address falls in the configuration-data window |
| cfg_addr | output | 32 | Latched configuration address |
| cfg_is_host | output | 1 | Latched address targets the host bridge |
| dev_irq | input | 128 | Device interrupt pins, four per device |
| irq_line | output | 16 | Shared interrupt vector |

## Verification
The scan is tried with five kinds of word, and each one separates a different fault in the priority logic:
- a single select at bit 11 or bit 31, which catches off-by-one errors at either end of the range;
- several selects set at once, which shows whether the lowest or the highest bit wins;
- low-only and all-zero words, which exercise the index-32 case that spills into the bus field;
- an all-ones word;
- big-endian words, which show whether the swap happens before the scan and after the rebuild.

Writes to the data window, to unrelated addresses and reads with the strobe low tell real decode from stray latching. Single and combined interrupt pins tell the modular fold apart from a plain slot offset.

// File: rtl/pcx_pkg.sv
package pcx_pkg;

    // Lowest bit position examined by the device-select scan
    localparam int SCAN_LO = 11;
    // Index reported when no select bit is set
    localparam int SCAN_NONE = 32;

    function automatic logic [31:0] byte_swap32(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

endpackage

// File: rtl/pcx_win_decode.sv
module pcx_win_decode #(
    parameter logic [31:0] BASE     = 32'hF280_0000,
    parameter int          WIN_LOG2 = 12
) (
    input  logic [31:0] addr,
    output logic        hit
);
    // Upper bits must match the base; the low WIN_LOG2 bits are the offset
    always_comb begin
        hit = ((addr ^ BASE) >> WIN_LOG2) == 32'd0;
    end
endmodule

// File: rtl/pcx_addr_reg.sv
module pcx_addr_reg
    import pcx_pkg::*;
#(
    parameter int HOST_DEV = 11
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        big_endian,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    output logic [31:0] rd_word,
    output logic [31:0] cfg_addr,
    output logic        is_host
);
    logic [31:0] w_le;
    logic [5:0]  scan_idx;
    logic [31:0] next_addr;
    logic [31:0] latch_q;
    logic [4:0]  dev_num;
    logic [31:0] rb_le;

    // Byte order fix-up, then priority scan: lowest set bit wins
    always_comb begin
        w_le     = big_endian ? byte_swap32(wdata) : wdata;
        scan_idx = 6'(SCAN_NONE);
        for (int b = 31; b >= SCAN_LO; b--) begin
            if (w_le[b]) scan_idx = 6'(b);
        end
        next_addr = 32'h8000_0000 | (w_le & 32'h0000_07FC) | (32'(scan_idx) << SCAN_LO);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     latch_q <= '0;
        else if (wr_en) latch_q <= next_addr;
    end

    // Rebuild the one-hot select form from the latched fields
    always_comb begin
        dev_num = latch_q[15:11];
        rb_le   = (32'd1 << dev_num)
                | {21'd0, latch_q[10:8], 8'd0}
                | (latch_q & 32'h0000_00FC);
        rd_word = big_endian ? byte_swap32(rb_le) : rb_le;
    end

    assign cfg_addr = latch_q;
    assign is_host  = latch_q[31] && (latch_q[23:16] == 8'd0) && (latch_q[15:11] == 5'(HOST_DEV));

    // R2
    enable_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> cfg_addr[31]);
    // R2
    field_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr[30:17] == 14'd0) && (cfg_addr[1:0] == 2'd0));
    // R3
    no_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (w_le[31:11] == 21'd0)) |=> (cfg_addr[16] && (cfg_addr[15:11] == 5'd0)));
    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_addr));
    // R4
    readback_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rb_le[31:11]) <= 1);
endmodule

// File: rtl/pcx_irq_swizzle.sv
module pcx_irq_swizzle #(
    parameter int SLOTS     = 32,
    parameter int PINS      = 4,
    parameter int IRQ_BASE  = 8,
    parameter int IRQ_LINES = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [SLOTS*PINS-1:0]  dev_irq,
    output logic [IRQ_LINES-1:0]   irq_line
);
    localparam logic [IRQ_LINES-1:0] LINE_MASK = IRQ_LINES'(((1 << PINS) - 1) << IRQ_BASE);

    // Pin p of slot s folds onto shared line (p + s) mod PINS
    always_comb begin
        irq_line = '0;
        for (int s = 0; s < SLOTS; s++) begin
            for (int p = 0; p < PINS; p++) begin
                irq_line[IRQ_BASE + ((p + s) % PINS)] =
                    irq_line[IRQ_BASE + ((p + s) % PINS)] | dev_irq[s*PINS + p];
            end
        end
    end

    // R8
    irq_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_line & ~LINE_MASK) == '0);
    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_irq == '0) |-> (irq_line == '0));
endmodule

// File: rtl/pcx_cfg_xlate.sv
module pcx_cfg_xlate #(
    parameter logic [31:0] ADDR_BASE   = 32'hF280_0000,
    parameter logic [31:0] DATA_OFFSET = 32'h0040_0000,
    parameter int          WIN_LOG2    = 12,
    parameter int          SLOTS       = 32,
    parameter int          PINS        = 4,
    parameter int          IRQ_BASE    = 8,
    parameter int          IRQ_LINES   = 16,
    parameter int          HOST_DEV    = 11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  big_endian,
    input  logic                  cpu_sel,
    input  logic                  cpu_we,
    input  logic [31:0]           cpu_addr,
    input  logic [31:0]           cpu_wdata,
    output logic [31:0]           cpu_rdata,
    output logic                  addr_win_hit,
    output logic                  data_win_hit,
    output logic [31:0]           cfg_addr,
    output logic                  cfg_is_host,
    input  logic [SLOTS*PINS-1:0] dev_irq,
    output logic [IRQ_LINES-1:0]  irq_line
);
    localparam logic [31:0] DATA_BASE = ADDR_BASE + DATA_OFFSET;

    logic        wr_en;
    logic        rd_en;
    logic [31:0] rd_word;

    pcx_win_decode #(.BASE(ADDR_BASE), .WIN_LOG2(WIN_LOG2)) u_addr_win (
        .addr (cpu_addr),
        .hit  (addr_win_hit)
    );

    pcx_win_decode #(.BASE(DATA_BASE), .WIN_LOG2(WIN_LOG2)) u_data_win (
        .addr (cpu_addr),
        .hit  (data_win_hit)
    );

    // Any access width is treated as a full word
    assign wr_en = cpu_sel &  cpu_we & addr_win_hit;
    assign rd_en = cpu_sel & ~cpu_we & addr_win_hit;

    pcx_addr_reg #(.HOST_DEV(HOST_DEV)) u_addr_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .big_endian (big_endian),
        .wr_en      (wr_en),
        .wdata      (cpu_wdata),
        .rd_word    (rd_word),
        .cfg_addr   (cfg_addr),
        .is_host    (cfg_is_host)
    );

    assign cpu_rdata = rd_en ? rd_word : 32'd0;

    pcx_irq_swizzle #(
        .SLOTS(SLOTS), .PINS(PINS), .IRQ_BASE(IRQ_BASE), .IRQ_LINES(IRQ_LINES)
    ) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .dev_irq  (dev_irq),
        .irq_line (irq_line)
    );

    // R6
    window_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_win_hit && data_win_hit));
    // R6
    outside_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_sel && cpu_we && !addr_win_hit) |=> $stable(cfg_addr));
    // R10
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_sel && !cpu_we) |-> (cpu_rdata == 32'd0));
endmodule

// File: tb/tb_pcx_cfg_xlate.sv
`timescale 1ns/1ps
module tb_pcx_cfg_xlate;
    localparam logic [31:0] ABASE = 32'hF280_0000;
    localparam logic [31:0] DBASE = 32'hF2C0_0000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         big_endian = 1'b0;
    logic         cpu_sel = 1'b0;
    logic         cpu_we = 1'b0;
    logic [31:0]  cpu_addr = '0;
    logic [31:0]  cpu_wdata = '0;
    logic [31:0]  cpu_rdata;
    logic         addr_win_hit;
    logic         data_win_hit;
    logic [31:0]  cfg_addr;
    logic         cfg_is_host;
    logic [127:0] dev_irq = '0;
    logic [15:0]  irq_line;

    always #2.5 clk = ~clk;

    pcx_cfg_xlate dut (
        .clk(clk), .rst_n(rst_n), .big_endian(big_endian),
        .cpu_sel(cpu_sel), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .addr_win_hit(addr_win_hit), .data_win_hit(data_win_hit),
        .cfg_addr(cfg_addr), .cfg_is_host(cfg_is_host),
        .dev_irq(dev_irq), .irq_line(irq_line)
    );

    typedef struct {
        int          kind;   // 0 cfg_addr, 1 rdata, 2 irq, 3 hits, 4 host flag
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t       sb_q[$];
    int          n_chk = 0;
    int          n_err = 0;
    bit          done = 0;
    logic [31:0] mdl = '0;

    function automatic logic [31:0] swp(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    // Expected latched address per R2/R3
    function automatic logic [31:0] exp_latch(input logic [31:0] w);
        int idx = 32;
        for (int b = 11; b < 32; b++) begin
            if (w[b]) begin idx = b; break; end
        end
        return 32'h8000_0000 | (w & 32'h7FC) | (32'(idx) << 11);
    endfunction

    // Expected read word per R4
    function automatic logic [31:0] exp_read(input logic [31:0] l);
        logic [31:0] r;
        r = 32'd0;
        r[l[15:11]] = 1'b1;
        r[10:2] = r[10:2] | l[10:2];
        return r;
    endfunction

    function automatic bit in_win(input logic [31:0] a, input logic [31:0] b);
        return a[31:12] == b[31:12];
    endfunction

    task automatic push(input int k, input logic [31:0] e, input string r);
        item_t it;
        it.kind = k; it.exp = e; it.req = r;
        sb_q.push_back(it);
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d, input bit be, input string r);
        @(negedge clk);
        cpu_sel = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d; big_endian = be;
        if (in_win(a, ABASE)) mdl = exp_latch(be ? swp(d) : d);
        push(0, mdl, r);
    endtask

    task automatic rd(input logic [31:0] a, input bit be, input string r);
        logic [31:0] e;
        @(negedge clk);
        cpu_sel = 1; cpu_we = 0; cpu_addr = a; big_endian = be;
        e = in_win(a, ABASE) ? (be ? swp(exp_read(mdl)) : exp_read(mdl)) : 32'd0;
        push(1, e, r);
        push(0, mdl, r);
    endtask

    task automatic idle();
        @(negedge clk);
        cpu_sel = 0; cpu_we = 0;
    endtask

    task automatic host_chk(input string r);
        logic h;
        @(negedge clk);
        cpu_sel = 0;
        h = mdl[31] && mdl[23:16] == 8'd0 && mdl[15:11] == 5'd11;
        push(4, {31'd0, h}, r);
    endtask

    task automatic hit_chk(input logic [31:0] a, input string r);
        @(negedge clk);
        cpu_sel = 0; cpu_addr = a;
        push(3, {30'd0, in_win(a, ABASE), in_win(a, DBASE)}, r);
    endtask

    task automatic irq_chk(input logic [127:0] v, input string r);
        logic [31:0] e;
        @(negedge clk);
        dev_irq = v;
        e = 32'd0;
        for (int s = 0; s < 32; s++)
            for (int p = 0; p < 4; p++)
                if (v[s*4+p]) e[8 + ((p + s) % 4)] = 1'b1;
        push(2, e, r);
    endtask

    // Monitor: compare every queued item just after the following edge
    initial begin
        item_t it;
        logic [31:0] act;
        forever begin
            @(posedge clk);
            #2;
            while (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                case (it.kind)
                    0: act = cfg_addr;
                    1: act = cpu_rdata;
                    2: act = {16'd0, irq_line};
                    3: act = {30'd0, addr_win_hit, data_win_hit};
                    default: act = {31'd0, cfg_is_host};
                endcase
                n_chk++;
                if (act !== it.exp) begin
                    n_err++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        // R1 reset state and reset readback
        idle(); push(0, 32'd0, "R1");
        rd(ABASE, 0, "R1");
        // R2 scan patterns
        wr(ABASE, 32'h0000_4A5C, 0, "R2"); rd(ABASE + 4, 0, "R4");
        wr(ABASE, 32'h8000_0124, 0, "R2"); rd(ABASE, 0, "R4");
        wr(ABASE + 32'hFFC, 32'h0012_3000, 0, "R2"); rd(ABASE, 0, "R4");
        wr(ABASE, 32'hFFFF_FFFF, 0, "R2"); rd(ABASE, 0, "R4");
        // R3 no select bit
        wr(ABASE, 32'h0000_07FF, 0, "R3"); rd(ABASE, 0, "R3");
        wr(ABASE, 32'h0000_0000, 0, "R3"); rd(ABASE, 0, "R3");
        // R9 host bridge select
        wr(ABASE, 32'h0000_0800, 0, "R9"); host_chk("R9");
        wr(ABASE, 32'h0000_1800, 0, "R9"); host_chk("R9");
        // R5 big-endian
        wr(ABASE, 32'h0008_0000, 1, "R5"); rd(ABASE, 1, "R5"); rd(ABASE, 0, "R5");
        wr(ABASE, 32'hFC01_0040, 1, "R5"); rd(ABASE, 1, "R5");
        // R6 writes outside the address window are ignored
        wr(DBASE, 32'h0000_0800, 0, "R6");
        wr(32'h1234_5678, 32'h0000_4000, 0, "R6");
        // R7 strobe low, and read, leave state alone
        @(negedge clk); cpu_sel = 0; cpu_we = 1; cpu_addr = ABASE; cpu_wdata = 32'h0010_0000;
        push(0, mdl, "R7");
        rd(ABASE, 0, "R7");
        // R10 read of data window returns zero
        rd(DBASE, 0, "R10"); rd(ABASE, 0, "R10"); idle(); push(1, 32'd0, "R10");
        // R6 decode
        hit_chk(ABASE + 32'h10, "R6"); hit_chk(DBASE + 32'hFFC, "R6");
        hit_chk(ABASE + 32'h1000, "R6"); hit_chk(ABASE - 4, "R6");
        // R8 interrupt fold
        irq_chk(128'd0, "R8");
        irq_chk(128'd1 << (0*4 + 0), "R8");
        irq_chk(128'd1 << (1*4 + 2), "R8");
        irq_chk(128'd1 << (11*4 + 3), "R8");
        irq_chk(128'd1 << (31*4 + 1), "R8");
        irq_chk((128'd1 << (1*4 + 3)) | (128'd1 << (2*4 + 2)), "R8");
        irq_chk(128'd1 << (5*4 + 0), "R8");
        idle(); idle(); idle();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule